// File: doc/BRIEF.md
# Power-Fail Store and Recall Controller

This controller sequences the backup and restore of a memory whose contents are copied into a nonvolatile array when power fails and copied back when power returns. It watches three digital comparator flags: supply below the switch threshold, supply below the reset threshold, and hold-capacitor below the switch threshold. It also shares an open-drain busy line, which it can pull low and which it reads back. From these it raises a store request, a recall request, a write inhibit and an access disable towards the memory interface. All inputs are taken as synchronous to `clk`.

When the supply sags, the controller pulls the busy line low for a short probe window. It then reads the line back. If another driver holds the line high, the store is abandoned. If no write has reached the memory since the last store, the store is skipped. Otherwise the controller gives a running memory cycle a bounded grace period and then requests the store while it keeps the line low. An outside agent can also request a store by holding the busy line low. A recall is owed from reset and whenever the supply falls below the reset level. That recall runs only after the supply is back above the switch threshold. A store request that arrives during a recall waits for the recall to finish, and a recall request that arrives during a store waits for the store to finish. All time limits are parameters counted in clock cycles, and one down-counter times whichever phase is active.

States: `ST_OFF` (supply down; leaves to `ST_RECALL` or `ST_IDLE` when the supply is above the switch threshold), `ST_IDLE` (normal use; to `ST_PROBE` on supply sag, to `ST_GRACE` on an outside store request), `ST_PROBE` (line pulled low; at expiry to `ST_LOWV` on abort or skip, else to `ST_GRACE`), `ST_GRACE` (to `ST_STORE` when the memory is idle or the grace period runs out), `ST_STORE` (to `ST_HOLD` at expiry), `ST_HOLD` (to `ST_RECOVER` once the line reads high), `ST_RECOVER` (at expiry to `ST_LOWV`, `ST_RECALL` or `ST_IDLE`), `ST_RECALL` (at expiry to `ST_GRACE` if a store waits, else to `ST_IDLE`), `ST_LOWV` (supply sagging with no store under way; to `ST_OFF` at reset level, else to `ST_RECALL` or `ST_IDLE` once the supply recovers).

Top module: `pfail_nv_seq`

## Requirements
- R1: After reset the controller is in `ST_OFF` with a recall owed: `acc_disable`=1, `wr_inhibit`=1, `store_req`=0, `recall_req`=0, `busy_pull_low`=0.
- R2: An owed recall is never issued while `sup_lo_sw`=1. Once `sup_lo_sw`=0, `recall_req` is high for exactly RECALL_CYC consecutive cycles. A recall becomes owed at reset and whenever `sup_lo_rst`=1.
- R3: A sag with `sup_lo_sw`=1 that never reaches `sup_lo_rst`=1 causes no recall when the supply recovers.
- R4: When `sup_lo_sw`=1 in `ST_IDLE`, `busy_pull_low` rises for ACK_CYC cycles. If the line then reads low and `mem_written`=1, the store follows: `store_req` is high for exactly STORE_CYC cycles, and `busy_pull_low` stays high through the grace period and the whole store.
- R5: If the busy line reads high at the end of the probe window, the controller releases the line after ACK_CYC cycles and issues no store.
- R6: If `mem_written`=0 at the end of the probe window, the controller releases the line after ACK_CYC cycles and issues no store.
- R7: A low on the busy line, not caused by this controller, that lasts at least HS_MIN_CYC consecutive cycles in `ST_IDLE` starts a store. A shorter low has no effect.
- R8: Before a store, the controller waits in the grace phase until `mem_active`=0, for at most GRACE_CYC cycles. With `mem_active`=0 the grace phase lasts one cycle.
- R9: After a store, `acc_disable` stays high until the busy line reads high. It then stays high for RECOVER_CYC more cycles.
- R10: While `cap_lo_sw`=1, `wr_inhibit`=1 and outside store requests are ignored.
- R11: An outside store request made during a recall is held. Its store starts after the recall ends.
- R12: A recall that becomes owed during a store starts after the store and its recovery, provided the supply is then above the switch threshold.
- R13: `store_req` and `recall_req` are never high together, and either one implies `acc_disable`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sup_lo_sw | input | 1 | Supply below switch threshold |
| sup_lo_rst | input | 1 | Supply below reset threshold |
| cap_lo_sw | input | 1 | Hold capacitor below switch threshold |
| busy_line_in | input | 1 | Read-back level of the shared busy line |
| mem_written | input | 1 | A write reached the memory since the last store |
| mem_active | input | 1 | A memory cycle is in progress |
| busy_pull_low | output | 1 | Pull the busy line low |
| store_req | output | 1 | Copy the memory to the nonvolatile array |
| recall_req | output | 1 | Copy the nonvolatile array back to the memory |
| wr_inhibit | output | 1 | Block memory writes |
| acc_disable | output | 1 | Block new memory accesses |

## Verification
The bench builds the controller with HS_MIN_CYC=3, ACK_CYC=2, GRACE_CYC=5, STORE_CYC=8, RECALL_CYC=6 and RECOVER_CYC=4. With these values every phase ends within a few dozen cycles. It sweeps the outside low-pulse width from 1 to 16 cycles, which covers lengths below the trigger width, at it, and past the end of the store. In each case the expected store length and access-disable length are computed from these parameters. It also exercises abort, skip, a grace period that runs out, brownout recall, capacitor inhibit, and both directions of the pending-request case.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_PROBE,
        ST_GRACE,
        ST_STORE,
        ST_HOLD,
        ST_RECOVER,
        ST_RECALL,
        ST_LOWV
    } pfs_state_e;

    function automatic int unsigned pfs_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfs_dncnt.sv
module pfs_dncnt #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pfs_lowpulse.sv
module pfs_lowpulse #(
    parameter int unsigned HS_MIN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_in,
    output logic hit
);
    localparam int unsigned CW = $clog2(HS_MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HS_MIN_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(HS_MIN_CYC);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (!en || line_in) begin
            run <= '0;
        end else if (run != SAT) begin
            run <= run + 1'b1;
        end
    end

    assign hit = en && !line_in && (run == LAST);
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
    import pfs_pkg::*;
#(
    parameter int unsigned TW          = 8,
    parameter int unsigned ACK_CYC     = 2,
    parameter int unsigned GRACE_CYC   = 100,
    parameter int unsigned STORE_CYC   = 1000,
    parameter int unsigned RECALL_CYC  = 2000,
    parameter int unsigned RECOVER_CYC = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sup_lo_sw,
    input  logic          sup_lo_rst,
    input  logic          cap_lo_sw,
    input  logic          busy_line_in,
    input  logic          mem_written,
    input  logic          mem_active,
    input  logic          hw_hit,
    input  logic          tmr_zero,
    output logic          det_en,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          busy_pull_low,
    output logic          store_req,
    output logic          recall_req,
    output logic          wr_inhibit,
    output logic          acc_disable
);
    pfs_state_e state, state_nxt;
    logic       recall_owed;
    logic       store_owed;
    logic       hw_ok;

    assign hw_ok = hw_hit && !cap_lo_sw;

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:
                if (!sup_lo_sw) state_nxt = recall_owed ? ST_RECALL : ST_IDLE;
            ST_IDLE:
                if (sup_lo_sw)  state_nxt = ST_PROBE;
                else if (hw_ok) state_nxt = ST_GRACE;
            ST_PROBE:
                if (tmr_zero) begin
                    if (busy_line_in || !mem_written) state_nxt = ST_LOWV;
                    else                              state_nxt = ST_GRACE;
                end
            ST_GRACE:
                if (!mem_active || tmr_zero) state_nxt = ST_STORE;
            ST_STORE:
                if (tmr_zero) state_nxt = ST_HOLD;
            ST_HOLD:
                if (busy_line_in) state_nxt = ST_RECOVER;
            ST_RECOVER:
                if (tmr_zero) begin
                    if (sup_lo_sw)        state_nxt = ST_LOWV;
                    else if (recall_owed) state_nxt = ST_RECALL;
                    else                  state_nxt = ST_IDLE;
                end
            ST_RECALL:
                if (tmr_zero) state_nxt = (store_owed || hw_ok) ? ST_GRACE : ST_IDLE;
            ST_LOWV:
                if (sup_lo_rst)      state_nxt = ST_OFF;
                else if (!sup_lo_sw) state_nxt = recall_owed ? ST_RECALL : ST_IDLE;
            default:
                state_nxt = ST_OFF;
        endcase
    end

    // state register and pending flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            recall_owed <= 1'b1;
            store_owed  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (sup_lo_rst)
                recall_owed <= 1'b1;
            else if (state_nxt == ST_RECALL && state != ST_RECALL)
                recall_owed <= 1'b0;
            if (state == ST_RECALL && state_nxt != ST_RECALL)
                store_owed <= 1'b0;
            else if (state == ST_RECALL && hw_ok)
                store_owed <= 1'b1;
        end
    end

    // shared phase timer, loaded on entry to each state
    assign tmr_load = (state_nxt != state);
    always_comb begin
        unique case (state_nxt)
            ST_PROBE:   tmr_val = TW'(ACK_CYC - 1);
            ST_GRACE:   tmr_val = TW'(GRACE_CYC - 1);
            ST_STORE:   tmr_val = TW'(STORE_CYC - 1);
            ST_RECOVER: tmr_val = TW'(RECOVER_CYC - 1);
            ST_RECALL:  tmr_val = TW'(RECALL_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    // outputs
    always_comb begin
        busy_pull_low = 1'b0;
        store_req     = 1'b0;
        recall_req    = 1'b0;
        acc_disable   = 1'b0;
        det_en        = 1'b0;
        unique case (state)
            ST_OFF:     acc_disable = 1'b1;
            ST_IDLE:    det_en = 1'b1;
            ST_PROBE:   busy_pull_low = 1'b1;
            ST_GRACE: begin
                busy_pull_low = 1'b1;
                acc_disable   = 1'b1;
            end
            ST_STORE: begin
                busy_pull_low = 1'b1;
                store_req     = 1'b1;
                acc_disable   = 1'b1;
            end
            ST_HOLD:    acc_disable = 1'b1;
            ST_RECOVER: acc_disable = 1'b1;
            ST_RECALL: begin
                recall_req  = 1'b1;
                acc_disable = 1'b1;
                det_en      = 1'b1;
            end
            ST_LOWV:    acc_disable = 1'b0;
            default:    acc_disable = 1'b1;
        endcase
        wr_inhibit = acc_disable || cap_lo_sw;
    end
endmodule

// File: rtl/pfail_nv_seq.sv
module pfail_nv_seq
    import pfs_pkg::*;
#(
    parameter int unsigned HS_MIN_CYC  = 2,
    parameter int unsigned ACK_CYC     = 2,
    parameter int unsigned GRACE_CYC   = 100,
    parameter int unsigned STORE_CYC   = 1000,
    parameter int unsigned RECALL_CYC  = 2000,
    parameter int unsigned RECOVER_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_lo_sw,
    input  logic sup_lo_rst,
    input  logic cap_lo_sw,
    input  logic busy_line_in,
    input  logic mem_written,
    input  logic mem_active,
    output logic busy_pull_low,
    output logic store_req,
    output logic recall_req,
    output logic wr_inhibit,
    output logic acc_disable
);
    localparam int unsigned TMAX = pfs_max(pfs_max(pfs_max(ACK_CYC, GRACE_CYC),
                                                   pfs_max(STORE_CYC, RECALL_CYC)),
                                           RECOVER_CYC);
    localparam int unsigned TW = $clog2(TMAX + 1);

    logic          det_en;
    logic          hw_hit;
    logic          tmr_load;
    logic          tmr_zero;
    logic [TW-1:0] tmr_val;

    pfs_lowpulse #(.HS_MIN_CYC(HS_MIN_CYC)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (det_en),
        .line_in (busy_line_in),
        .hit     (hw_hit)
    );

    pfs_dncnt #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    pfs_fsm #(
        .TW          (TW),
        .ACK_CYC     (ACK_CYC),
        .GRACE_CYC   (GRACE_CYC),
        .STORE_CYC   (STORE_CYC),
        .RECALL_CYC  (RECALL_CYC),
        .RECOVER_CYC (RECOVER_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sup_lo_sw     (sup_lo_sw),
        .sup_lo_rst    (sup_lo_rst),
        .cap_lo_sw     (cap_lo_sw),
        .busy_line_in  (busy_line_in),
        .mem_written   (mem_written),
        .mem_active    (mem_active),
        .hw_hit        (hw_hit),
        .tmr_zero      (tmr_zero),
        .det_en        (det_en),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .busy_pull_low (busy_pull_low),
        .store_req     (store_req),
        .recall_req    (recall_req),
        .wr_inhibit    (wr_inhibit),
        .acc_disable   (acc_disable)
    );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk (
    input logic clk,
    input logic rst_n,
    input logic sup_lo_sw,
    input logic cap_lo_sw,
    input logic busy_pull_low,
    input logic store_req,
    input logic recall_req,
    input logic wr_inhibit,
    input logic acc_disable
);
    a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    a_r13_store_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> acc_disable);

    a_r13_recall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> acc_disable);

    a_r4_line_held: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> busy_pull_low);

    a_r8_grace_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> $past(busy_pull_low));

    a_r10_cap_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lo_sw |-> wr_inhibit);

    a_r2_recall_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_req) |-> !sup_lo_sw);
endmodule

bind pfail_nv_seq pfs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_lo_sw     (sup_lo_sw),
    .cap_lo_sw     (cap_lo_sw),
    .busy_pull_low (busy_pull_low),
    .store_req     (store_req),
    .recall_req    (recall_req),
    .wr_inhibit    (wr_inhibit),
    .acc_disable   (acc_disable)
);

// File: tb/tb_pfail_nv_seq.sv
`timescale 1ns/1ps
module tb_pfail_nv_seq;
    localparam int HS = 3, ACK = 2, GR = 5, ST = 8, RC = 6, RV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_lo_sw = 1'b1, sup_lo_rst = 1'b1, cap_lo_sw = 1'b0;
    logic mem_written = 1'b0, mem_active = 1'b0;
    logic ext_low = 1'b0, ext_high = 1'b0;
    logic busy_line_in, busy_pull_low, store_req, recall_req, wr_inhibit, acc_disable;

    int total = 0, bad = 0;
    int idx = 0;
    int n_st, n_rc, n_acc, n_pull, n_grace, n_wi;
    int f_st, l_st, f_rc, l_rc;

    always #5 clk = ~clk;

    assign busy_line_in = ext_high ? 1'b1 : ~(busy_pull_low | ext_low);

    pfail_nv_seq #(
        .HS_MIN_CYC(HS), .ACK_CYC(ACK), .GRACE_CYC(GR),
        .STORE_CYC(ST), .RECALL_CYC(RC), .RECOVER_CYC(RV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sup_lo_sw(sup_lo_sw), .sup_lo_rst(sup_lo_rst),
        .cap_lo_sw(cap_lo_sw), .busy_line_in(busy_line_in), .mem_written(mem_written),
        .mem_active(mem_active), .busy_pull_low(busy_pull_low), .store_req(store_req),
        .recall_req(recall_req), .wr_inhibit(wr_inhibit), .acc_disable(acc_disable)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        n_st = 0; n_rc = 0; n_acc = 0; n_pull = 0; n_grace = 0; n_wi = 0;
        f_st = -1; l_st = -1; f_rc = -1; l_rc = -1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idx++;
        if (store_req) begin n_st++; if (f_st < 0) f_st = idx; l_st = idx; end
        if (recall_req) begin n_rc++; if (f_rc < 0) f_rc = idx; l_rc = idx; end
        if (acc_disable) n_acc++;
        if (busy_pull_low) n_pull++;
        if (busy_pull_low && !store_req) n_grace++;
        if (wr_inhibit) n_wi++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr();
        steps(3);
        rst_n = 1'b1;
        steps(1);
        // R1 reset state
        chk("R1 acc_disable", int'(acc_disable), 1);
        chk("R1 wr_inhibit", int'(wr_inhibit), 1);
        chk("R1 store_req", int'(store_req), 0);
        chk("R1 recall_req", int'(recall_req), 0);
        chk("R1 busy_pull_low", int'(busy_pull_low), 0);

        // R2 no recall while supply low, then exactly RC cycles
        clr(); steps(10);
        chk("R2 recall held while low", n_rc, 0);
        sup_lo_rst = 1'b0; steps(2);
        sup_lo_sw = 1'b0;
        clr(); steps(20);
        chk("R2 power-up recall length", n_rc, RC);
        chk("R2 access back after recall", int'(acc_disable), 0);

        // R7 / R9 sweep of outside low-pulse width
        for (int len = 1; len <= 16; len++) begin
            clr();
            ext_low = 1'b1;
            steps(len);
            ext_low = 1'b0;
            steps(40 - len);
            chk($sformatf("R7 store for pulse %0d", len), n_st, (len >= HS) ? ST : 0);
            chk($sformatf("R9 disable span for pulse %0d", len), n_acc,
                (len >= HS) ? ((len - HS + 1 + RV > 2 + ST + RV) ? len - HS + 1 + RV : 2 + ST + RV) : 0);
            if (len == HS) chk("R8 grace with idle memory", n_grace, 1);
        end

        // R8 grace runs out with memory busy
        mem_active = 1'b1;
        clr(); ext_low = 1'b1; steps(4); ext_low = 1'b0; steps(36);
        chk("R8 grace bounded", n_grace, GR);
        chk("R8 store after grace", n_st, ST);
        mem_active = 1'b0;

        // R4 automatic store
        mem_written = 1'b1; sup_lo_sw = 1'b1;
        clr(); steps(30);
        chk("R4 auto store length", n_st, ST);
        chk("R4 line held low span", n_pull, ACK + 1 + ST);
        chk("R4 access open in low-supply wait", int'(acc_disable), 0);
        // R3 recovery without reset-level dip
        sup_lo_sw = 1'b0;
        clr(); steps(15);
        chk("R3 no recall after shallow sag", n_rc, 0);

        // R5 abort when line held high elsewhere
        ext_high = 1'b1; sup_lo_sw = 1'b1;
        clr(); steps(20);
        chk("R5 abort pull span", n_pull, ACK);
        chk("R5 abort no store", n_st, 0);
        sup_lo_sw = 1'b0; steps(3); ext_high = 1'b0; steps(2);

        // R6 skip without write
        mem_written = 1'b0; sup_lo_sw = 1'b1;
        clr(); steps(20);
        chk("R6 skip pull span", n_pull, ACK);
        chk("R6 skip no store", n_st, 0);
        // R2 brownout recall
        sup_lo_rst = 1'b1; steps(3); sup_lo_rst = 1'b0; steps(2);
        sup_lo_sw = 1'b0;
        clr(); steps(20);
        chk("R2 brownout recall length", n_rc, RC);

        // R10 capacitor low
        cap_lo_sw = 1'b1; steps(1);
        chk("R10 inhibit on cap low", int'(wr_inhibit), 1);
        chk("R10 access still open", int'(acc_disable), 0);
        clr(); ext_low = 1'b1; steps(6); ext_low = 1'b0; steps(24);
        chk("R10 outside request ignored", n_st, 0);
        chk("R10 inhibit held", n_wi, 30);
        cap_lo_sw = 1'b0; steps(1);
        chk("R10 inhibit released", int'(wr_inhibit), 0);

        // R11 outside request during recall
        sup_lo_sw = 1'b1; steps(6);
        sup_lo_rst = 1'b1; steps(2); sup_lo_rst = 1'b0;
        clr(); idx = 0;
        for (int i = 1; i <= 40; i++) begin
            sup_lo_sw = 1'b0;
            ext_low = (i >= 2 && i <= 5);
            step();
        end
        ext_low = 1'b0;
        chk("R11 recall length", n_rc, RC);
        chk("R11 held store length", n_st, ST);
        chk("R11 store after recall", int'(f_st > l_rc), 1);

        // R12 recall owed during store
        clr(); idx = 0;
        for (int i = 1; i <= 40; i++) begin
            ext_low = (i <= 3);
            sup_lo_sw = (i == 7 || i == 8);
            sup_lo_rst = (i == 7 || i == 8);
            step();
        end
        ext_low = 1'b0; sup_lo_sw = 1'b0; sup_lo_rst = 1'b0;
        chk("R12 store length", n_st, ST);
        chk("R12 held recall length", n_rc, RC);
        chk("R12 recall after store", int'(f_rc > l_st), 1);
        chk("R12 recall waits for recovery", f_rc - l_st, 2 + RV);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule